// File: doc/BRIEF.md
# Peripheral Protection Permission Gate

This block holds the three per-port permission masks of one peripheral protection controller and turns them into the per-port signals that the controller uses to gate bus traffic. The masks are: a security mask, which marks each port as non-secure or secure; a secure-privilege mask; and a non-secure-privilege mask. The secure register bank writes the security mask and the secure-privilege mask. The non-secure register bank writes the non-secure-privilege mask. Each port's privilege output is taken from the privilege mask that belongs to that port's current security state.

The block also carries this controller's share of the shared interrupt registers. That share is a single status bit and a single enable bit, placed at a bit position fixed by the controller's kind and index. The status bit captures the controller's interrupt level. It can be cleared through a write-only clear register. The enable bit and the status bit are each driven out to the controller. A few register offsets belong to a permission controller that does not exist. They read as zero and ignore writes.

The block is placed once per controller, with parameters for the port count, the controller kind and index, and the register offsets. All outputs come from registers.

Top module: `ppg_gate`

## Requirements
- R1: For each port i, `apOut[i]` equals the non-secure-privilege mask bit i when security mask bit i is 1, and the secure-privilege mask bit i when it is 0.
- R2: `nonsecOut` mirrors the security mask. A secure-bank write at NS_OFS (default 0x080) loads the mask, and a secure-bank read there returns it.
- R3: Each mask stores only its low NUM_PORTS bits. Higher written bits are dropped, and they read back as zero.
- R4: Only the secure bank can write the security mask and the secure-privilege mask (SP_OFS, default 0x0C0). Only the non-secure bank can write the non-secure-privilege mask (NSP_OFS, default 0x0C0). A write at the same offset through the other bank leaves the mask unchanged.
- R5: A write is captured on the clock edge where `wrEn` is high. The outputs change on the next clock edge. `rdData` is registered one edge after `rdEn`, and it is zero when no readable register is selected.
- R6: The absent controller's offsets (secure 0x050 and 0x090, non-secure 0x090) read zero and ignore writes.
- R7: The interrupt bit position is 0 or 1 for internal APB controller 0 or 1, 4+i for expansion APB controller i, and 20+i for expansion AHB controller i. A secure write at INT_EN_OFS (default 0x028) loads `wrData` at that bit. `irqEnableOut` follows it, and a read returns it at that bit.
- R8: When `irqStatusIn` differs from its value on the previous edge, the status bit takes the new level. `irqClearOut` follows the status bit, and a secure read at INT_STAT_OFS (default 0x020) returns it at the interrupt bit position.
- R9: A secure write at INT_CLR_OFS (default 0x024) with the interrupt bit set clears the status bit. A change of `irqStatusIn` on the same edge takes precedence. Writing 0 at that bit, or writing the status register itself, has no effect.
- R10: Reset clears all three masks, the enable and status bits, and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secSel | input | 1 | 1 selects the secure bank, 0 the non-secure bank |
| wrEn | input | 1 | Word write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset within the bank |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| irqStatusIn | input | 1 | Interrupt level from the controller |
| nonsecOut | output | NUM_PORTS | Per-port non-secure indication |
| apOut | output | NUM_PORTS | Per-port privilege-access indication |
| irqEnableOut | output | 1 | Interrupt enable for the controller |
| irqClearOut | output | 1 | Status-bit follower for the controller |

## Verification
A mask or enable write is captured on one edge, and the matching output changes one edge later. The bench drives on falling edges. After the capture edge, it first confirms at that falling edge that the output still shows the old value, then checks the new value one falling edge later. Read data is due one edge after `rdEn`, so it is sampled at the falling edge that follows. A level change on `irqStatusIn` takes two edges to reach `irqClearOut`, so that output is checked two falling edges after the change.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef enum logic [1:0] {
    CK_APB_INT = 2'd0,
    CK_APB_EXP = 2'd1,
    CK_AHB_EXP = 2'd2
  } ctrlKind_e;

  // Decoded per-access strobes passed from control to datapath
  typedef struct packed {
    logic wrNs;
    logic wrSp;
    logic wrNsp;
    logic wrIrqEn;
    logic wrIrqClr;
    logic rdNs;
    logic rdSp;
    logic rdNsp;
    logic rdIrqStat;
    logic rdIrqEn;
  } strobe_t;

  // Bit position of a controller inside the shared interrupt registers
  function automatic int irqBitFor(ctrlKind_e kind, int idx);
    case (kind)
      CK_APB_INT: irqBitFor = idx;
      CK_APB_EXP: irqBitFor = 4 + idx;
      default:    irqBitFor = 20 + idx;
    endcase
  endfunction

endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] NS_OFS       = 12'h080,
  parameter logic [ADDR_W-1:0] SP_OFS       = 12'h0C0,
  parameter logic [ADDR_W-1:0] NSP_OFS      = 12'h0C0,
  parameter logic [ADDR_W-1:0] INT_STAT_OFS = 12'h020,
  parameter logic [ADDR_W-1:0] INT_CLR_OFS  = 12'h024,
  parameter logic [ADDR_W-1:0] INT_EN_OFS   = 12'h028
) (
  input  logic              secSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ppg_pkg::strobe_t  strobe
);
  logic sWr, nWr, sRd, nRd;

  always_comb begin
    sWr = wrEn & secSel;
    nWr = wrEn & ~secSel;
    sRd = rdEn & secSel;
    nRd = rdEn & ~secSel;
    // Absent-controller offsets match nothing here, so they read zero and drop writes
    strobe.wrNs      = sWr && (addr == NS_OFS);
    strobe.wrSp      = sWr && (addr == SP_OFS);
    strobe.wrNsp     = nWr && (addr == NSP_OFS);
    strobe.wrIrqEn   = sWr && (addr == INT_EN_OFS);
    strobe.wrIrqClr  = sWr && (addr == INT_CLR_OFS);
    strobe.rdNs      = sRd && (addr == NS_OFS);
    strobe.rdSp      = sRd && (addr == SP_OFS);
    strobe.rdNsp     = nRd && (addr == NSP_OFS);
    strobe.rdIrqStat = sRd && (addr == INT_STAT_OFS);
    strobe.rdIrqEn   = sRd && (addr == INT_EN_OFS);
  end
endmodule

// File: rtl/ppg_dpath.sv
module ppg_dpath #(
  parameter int NUM_PORTS = 16,
  parameter int DATA_W    = 32,
  parameter int IRQ_BIT   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ppg_pkg::strobe_t     strobe,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 irqStatusIn,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_PORTS-1:0] nsMask,
  output logic [NUM_PORTS-1:0] spMask,
  output logic [NUM_PORTS-1:0] nspMask,
  output logic [NUM_PORTS-1:0] nonsecOut,
  output logic [NUM_PORTS-1:0] apOut,
  output logic                 irqEnableOut,
  output logic                 irqClearOut
);
  logic                 irqEn, irqStat, lvlPrev, lvlChanged;
  logic [NUM_PORTS-1:0] apNext;
  logic [DATA_W-1:0]    rdNext;

  // Mask storage; only the low NUM_PORTS bits of a write are kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nsMask  <= '0;
      spMask  <= '0;
      nspMask <= '0;
    end else begin
      if (strobe.wrNs)  nsMask  <= wrData[NUM_PORTS-1:0];
      if (strobe.wrSp)  spMask  <= wrData[NUM_PORTS-1:0];
      if (strobe.wrNsp) nspMask <= wrData[NUM_PORTS-1:0];
    end
  end

  // Per-port privilege select
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign apNext[p] = nsMask[p] ? nspMask[p] : spMask[p];
  end

  assign lvlChanged = irqStatusIn ^ lvlPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      irqStat <= 1'b0;
      lvlPrev <= 1'b0;
    end else begin
      lvlPrev <= irqStatusIn;
      if (strobe.wrIrqEn) irqEn <= wrData[IRQ_BIT];
      if (lvlChanged) irqStat <= irqStatusIn;
      else if (strobe.wrIrqClr && wrData[IRQ_BIT]) irqStat <= 1'b0;
    end
  end

  always_comb begin
    rdNext = '0;
    if (strobe.rdNs)      rdNext[NUM_PORTS-1:0] = nsMask;
    if (strobe.rdSp)      rdNext[NUM_PORTS-1:0] = spMask;
    if (strobe.rdNsp)     rdNext[NUM_PORTS-1:0] = nspMask;
    if (strobe.rdIrqStat) rdNext[IRQ_BIT]       = irqStat;
    if (strobe.rdIrqEn)   rdNext[IRQ_BIT]       = irqEn;
  end

  // Registered outputs: no combinational path from the bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nonsecOut    <= '0;
      apOut        <= '0;
      irqEnableOut <= 1'b0;
      irqClearOut  <= 1'b0;
      rdData       <= '0;
    end else begin
      nonsecOut    <= nsMask;
      apOut        <= apNext;
      irqEnableOut <= irqEn;
      irqClearOut  <= irqStat;
      rdData       <= rdNext;
    end
  end
endmodule

// File: rtl/ppg_gate.sv
module ppg_gate #(
  parameter int NUM_PORTS = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter ppg_pkg::ctrlKind_e CTRL_KIND = ppg_pkg::CK_APB_EXP,
  parameter int CTRL_IDX  = 0,
  parameter logic [ADDR_W-1:0] NS_OFS       = 12'h080,
  parameter logic [ADDR_W-1:0] SP_OFS       = 12'h0C0,
  parameter logic [ADDR_W-1:0] NSP_OFS      = 12'h0C0,
  parameter logic [ADDR_W-1:0] INT_STAT_OFS = 12'h020,
  parameter logic [ADDR_W-1:0] INT_CLR_OFS  = 12'h024,
  parameter logic [ADDR_W-1:0] INT_EN_OFS   = 12'h028
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 secSel,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 irqStatusIn,
  output logic [NUM_PORTS-1:0] nonsecOut,
  output logic [NUM_PORTS-1:0] apOut,
  output logic                 irqEnableOut,
  output logic                 irqClearOut
);
  localparam int IRQ_BIT = ppg_pkg::irqBitFor(CTRL_KIND, CTRL_IDX);

  ppg_pkg::strobe_t     strobe;
  logic [NUM_PORTS-1:0] nsMask, spMask, nspMask;

  ppg_ctrl #(
    .ADDR_W(ADDR_W), .NS_OFS(NS_OFS), .SP_OFS(SP_OFS), .NSP_OFS(NSP_OFS),
    .INT_STAT_OFS(INT_STAT_OFS), .INT_CLR_OFS(INT_CLR_OFS), .INT_EN_OFS(INT_EN_OFS)
  ) u_ctrl (
    .secSel(secSel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strobe(strobe)
  );

  ppg_dpath #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .IRQ_BIT(IRQ_BIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .irqStatusIn(irqStatusIn), .rdData(rdData),
    .nsMask(nsMask), .spMask(spMask), .nspMask(nspMask),
    .nonsecOut(nonsecOut), .apOut(apOut),
    .irqEnableOut(irqEnableOut), .irqClearOut(irqClearOut)
  );
endmodule

// File: rtl/ppg_gate_chk.sv
module ppg_gate_chk #(
  parameter int NUM_PORTS = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int IRQ_BIT   = 4,
  parameter logic [ADDR_W-1:0] NS_OFS     = 12'h080,
  parameter logic [ADDR_W-1:0] INT_EN_OFS = 12'h028
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 secSel,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic                 irqStatusIn,
  input logic [NUM_PORTS-1:0] nonsecOut,
  input logic [NUM_PORTS-1:0] apOut,
  input logic                 irqEnableOut,
  input logic                 irqClearOut,
  input logic [NUM_PORTS-1:0] nsMask,
  input logic [NUM_PORTS-1:0] spMask,
  input logic [NUM_PORTS-1:0] nspMask
);
  // R1
  ap_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> apOut == $past((nsMask & nspMask) | (~nsMask & spMask)));

  // R2
  nonsec_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && secSel && addr == NS_OFS) |-> ##2 (nonsecOut == $past(wrData[NUM_PORTS-1:0], 2)));

  // R6
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == 12'h050 || addr == 12'h090)) |=> rdData == '0);

  // R7
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && secSel && addr == INT_EN_OFS) |-> ##2 (irqEnableOut == $past(wrData[IRQ_BIT], 2)));

  // R8
  status_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatusIn) |-> ##2 irqClearOut);
endmodule

bind ppg_gate ppg_gate_chk #(
  .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_BIT(IRQ_BIT),
  .NS_OFS(NS_OFS), .INT_EN_OFS(INT_EN_OFS)
) u_chk (.*);

// File: tb/ppg_gate_tb.sv
module ppg_gate_tb;
  localparam int NP = 16;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int IB = 4; // expansion APB controller 0 -> bit 4 (R7)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0, irqStatusIn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [NP-1:0] nonsecOut, apOut;
  logic irqEnableOut, irqClearOut;
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  ppg_gate u_dut (
    .clk(clk), .rstN(rstN), .secSel(secSel), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqStatusIn(irqStatusIn),
    .nonsecOut(nonsecOut), .apOut(apOut),
    .irqEnableOut(irqEnableOut), .irqClearOut(irqClearOut)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Ends at the falling edge after the capture edge
  task automatic busWrite(logic s, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    secSel = s; addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic s, logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    secSel = s; addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic testReset();
    logic [DW-1:0] d;
    check("R10 nonsec", DW'(nonsecOut), 0);
    check("R10 ap", DW'(apOut), 0);
    check("R10 irq", {30'd0, irqEnableOut, irqClearOut}, 0);
    busRead(1'b1, 12'h080, d); check("R10 ns mask", d, 0);
    busRead(1'b0, 12'h0C0, d); check("R10 nsp mask", d, 0);
  endtask

  task automatic testNsMirror();
    logic [DW-1:0] d;
    busWrite(1'b1, 12'h080, 32'h0000_A5C3);
    check("R5 old value held", DW'(nonsecOut), 0);
    @(negedge clk);
    check("R2 nonsec", DW'(nonsecOut), 32'h0000_A5C3);
    busRead(1'b1, 12'h080, d); check("R2 readback", d, 32'h0000_A5C3);
  endtask

  task automatic testPortMask();
    logic [DW-1:0] d;
    busWrite(1'b1, 12'h080, 32'hFFFF_FFFF);
    busRead(1'b1, 12'h080, d); check("R3 ns truncate", d, 32'h0000_FFFF);
    busWrite(1'b0, 12'h0C0, 32'hABCD_0000);
    busRead(1'b0, 12'h0C0, d); check("R3 nsp truncate", d, 32'h0);
  endtask

  task automatic testApSelect(logic [NP-1:0] ns, logic [NP-1:0] sp, logic [NP-1:0] nsp);
    logic [NP-1:0] expAp;
    busWrite(1'b1, 12'h080, DW'(ns));
    busWrite(1'b1, 12'h0C0, DW'(sp));
    busWrite(1'b0, 12'h0C0, DW'(nsp));
    @(negedge clk);
    for (int i = 0; i < NP; i++) expAp[i] = ns[i] ? nsp[i] : sp[i];
    check("R1 ap select", DW'(apOut), DW'(expAp));
  endtask

  task automatic testBankSeparation();
    logic [DW-1:0] d;
    busWrite(1'b0, 12'h080, 32'h0000_1234);
    @(negedge clk);
    check("R4 ns via nonsecure bank", DW'(nonsecOut), 32'h0000_00FF);
    busRead(1'b0, 12'h0C0, d); check("R4 nsp kept", d, 32'h0000_3333);
    busWrite(1'b1, 12'h0C0, 32'h0000_F0F0);
    busRead(1'b0, 12'h0C0, d); check("R4 nsp unaffected by secure", d, 32'h0000_3333);
    busRead(1'b1, 12'h0C0, d); check("R4 sp updated", d, 32'h0000_F0F0);
  endtask

  task automatic testAbsent();
    logic [DW-1:0] d;
    logic [NP-1:0] ns0, ap0;
    ns0 = nonsecOut; ap0 = apOut;
    busWrite(1'b1, 12'h050, 32'hFFFF_FFFF);
    busWrite(1'b1, 12'h090, 32'hFFFF_FFFF);
    busWrite(1'b0, 12'h090, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R6 outputs unchanged", {nonsecOut, apOut}, {ns0, ap0});
    busRead(1'b1, 12'h050, d); check("R6 s 0x050", d, 0);
    busRead(1'b1, 12'h090, d); check("R6 s 0x090", d, 0);
    busRead(1'b0, 12'h090, d); check("R6 ns 0x090", d, 0);
  endtask

  task automatic testIrqEnable();
    logic [DW-1:0] d;
    busWrite(1'b1, 12'h028, 32'h0000_0010);
    check("R5 enable not yet", DW'(irqEnableOut), 0);
    @(negedge clk);
    check("R7 enable set", DW'(irqEnableOut), 1);
    busRead(1'b1, 12'h028, d); check("R7 enable readback", d, 32'h1 << IB);
    busWrite(1'b1, 12'h028, 32'hFFFF_FFEF);
    @(negedge clk);
    check("R7 enable other bits", DW'(irqEnableOut), 0);
  endtask

  task automatic testIrqStatus();
    logic [DW-1:0] d;
    @(negedge clk); irqStatusIn = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 clear out follows", DW'(irqClearOut), 1);
    busRead(1'b1, 12'h020, d); check("R8 status read", d, 32'h1 << IB);
    busWrite(1'b1, 12'h020, 32'h0);
    busWrite(1'b1, 12'h024, 32'hFFFF_FFEF);
    @(negedge clk);
    check("R9 other clear bits ignored", DW'(irqClearOut), 1);
    busWrite(1'b1, 12'h024, 32'h1 << IB);
    @(negedge clk);
    check("R9 cleared while level high", DW'(irqClearOut), 0);
    @(negedge clk); irqStatusIn = 1'b0;
    @(negedge clk);
    // Rising level and clear on the same edge: the change wins
    secSel = 1'b1; addr = 12'h024; wrData = 32'h1 << IB; wrEn = 1'b1; irqStatusIn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
    check("R9 change beats clear", DW'(irqClearOut), 1);
    irqStatusIn = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 falling level", DW'(irqClearOut), 0);
  endtask

  task automatic testMidReset();
    busWrite(1'b1, 12'h080, 32'h0000_FFFF);
    busWrite(1'b1, 12'h028, 32'h1 << IB);
    @(negedge clk); @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 nonsec after reset", DW'(nonsecOut), 0);
    check("R10 enable after reset", DW'(irqEnableOut), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNsMirror();
    testPortMask();
    testApSelect(16'h00FF, 16'h0F0F, 16'h3333);
    testBankSeparation();
    testApSelect(16'hF00F, 16'h5A5A, 16'hC3C3);
    testAbsent();
    testIrqEnable();
    testIrqStatus();
    testMidReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #40000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule